// File: doc/BRIEF.md
# Protection Region Configuration Registers

This block is the register file behind a physical memory protection unit. It keeps one configuration byte and one address word per protection entry, plus a small security-configuration register. Software reaches it through CSR-style read and write strobes. A write to a packed configuration CSR carries several entry bytes at once. Each byte lands on its own entry, or is dropped, according to a lock policy. The security bits change that policy.

Address writes are guarded in two ways. An entry's own lock guards its address. So does the lock of the following entry when that entry matches in top-of-range mode, because it uses this address as its lower bound. The security register holds two sticky bits and a guarded bypass bit. Every entry's configuration and address is driven out flat to the range decoder and permission checker. A one-cycle flush pulse follows each configuration CSR write, so that cached permissions can be discarded. The enhanced-security policy is selected by a parameter. With it cleared, the block falls back to the plain lock rule.

Top module: `prot_region_regs`

## Requirements
- R1: After reset every configuration byte, every address word and the security register read as zero, and `flush` is low.
- R2: A configuration CSR write with index k sends byte i of `wr_data` (bits 8i+7..8i) to entry 4k+i, for i below XLEN/8. A configuration read of index k packs the bytes in the same way. Each byte has read, write and execute in bits 0, 1 and 2, the match mode in bits 4:3 (01 = top-of-range) and the lock in bit 7.
- R3: With the enhanced policy disabled, a byte written to an entry whose lock bit is already set is dropped. A byte written to an unlocked entry is stored.
- R4: With the enhanced policy, every byte write is stored while the bypass bit (security bit 2) is set. With bypass and lockdown (security bit 0) both clear, a byte is stored only when the target entry is unlocked.
- R5: With the enhanced policy and lockdown set, a byte is stored when it has lock set and execute clear. It is also stored when it has lock clear and bits 2:0 differ from 3'b110. Any other byte is dropped, unless bypass is set.
- R6: An address write to an entry whose lock bit is set is dropped. An address write to an entry with no lock from itself or its successor is stored.
- R7: An address write to entry j is dropped when entry j+1 has lock set and match mode 01. A locked successor in any other mode does not block the write.
- R8: Writes to an entry index at or above the number of entries have no effect, and reads of such an index return zero. A read with kind 3 returns zero.
- R9: Security bits 0 (lockdown) and 1 (whitelist policy) are sticky: once set, later writes cannot clear them.
- R10: The bypass bit cannot go from 0 to 1 while any entry is locked. When no entry is locked, it can be set.
- R11: A write changes state on the clock edge that samples its strobe, and is visible from then on. `flush` is high for exactly the one cycle after each configuration CSR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 2 | Write target: 0 config CSR, 1 address, 2 security, 3 none |
| wr_idx | input | IDX_W | CSR index for the write |
| wr_data | input | XLEN | Write data |
| rd_kind | input | 2 | Read target, same encoding as wr_kind |
| rd_idx | input | IDX_W | CSR index for the read |
| rd_data | output | XLEN | Combinational read data |
| cfg_flat | output | 8*N_ENTRIES | All configuration bytes, entry e at bits 8e+7..8e |
| addr_flat | output | XLEN*N_ENTRIES | All address words, entry e at word e |
| sec_state | output | 3 | Security bits: 0 lockdown, 1 whitelist, 2 bypass |
| flush | output | 1 | One-cycle pulse after a config CSR write |

## Verification
Reads are combinational, so any register value is visible one edge after its write strobe. The bench therefore drives each write for one cycle from a falling edge and queues its expected read-backs only after the strobe has dropped. The falling-edge monitor sets the read index and compares half a cycle later. `flush` is due in the cycle right after the write edge and must be gone one cycle later. One check samples the outputs while the strobe is still high, to confirm that nothing changes before the edge.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

  localparam int BIT_RD   = 0;
  localparam int BIT_WR   = 1;
  localparam int BIT_EX   = 2;
  localparam int BIT_LOCK = 7;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_TOR = 2'b01;

  localparam int SEC_LOCKDOWN  = 0;
  localparam int SEC_WHITELIST = 1;
  localparam int SEC_BYPASS    = 2;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_SEC  = 2'd2,
    KIND_NONE = 2'd3
  } csr_kind_e;

  function automatic logic [1:0] mode_of(input logic [7:0] c);
    return c[4:3];
  endfunction

  // Lock policy for one configuration byte
  function automatic logic cfg_write_ok(input logic enhanced, input logic bypass,
                                        input logic lockdown, input logic old_lock,
                                        input logic [7:0] nv);
    logic ok;
    ok = 1'b0;
    if (!enhanced) begin
      ok = !old_lock;
    end else begin
      if (bypass) ok = 1'b1;
      if (!lockdown && !old_lock) ok = 1'b1;
      if (lockdown) begin
        if (nv[BIT_LOCK] && !nv[BIT_EX]) ok = 1'b1;
        if (!nv[BIT_LOCK] && (nv[2:0] != 3'b110)) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  // Address write is blocked by own lock or by a locked top-of-range successor
  function automatic logic addr_write_ok(input logic self_lock, input logic has_next,
                                         input logic [7:0] next_cfg);
    logic succ_block;
    succ_block = has_next && next_cfg[BIT_LOCK] && (mode_of(next_cfg) == MODE_TOR);
    return !self_lock && !succ_block;
  endfunction

  function automatic logic [2:0] sec_next(input logic [2:0] cur, input logic [2:0] wv,
                                          input logic any_locked);
    logic [2:0] n;
    n = wv;
    if (!cur[SEC_BYPASS] && any_locked) n[SEC_BYPASS] = 1'b0;
    n[SEC_LOCKDOWN]  = n[SEC_LOCKDOWN]  | cur[SEC_LOCKDOWN];
    n[SEC_WHITELIST] = n[SEC_WHITELIST] | cur[SEC_WHITELIST];
    return n;
  endfunction

endpackage

// File: rtl/prot_entry.sv
module prot_entry
  import prot_region_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit ENHANCED = 1'b1,
  parameter bit HAS_NEXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wdata,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic            bypass,
  input  logic            lockdown,
  input  logic [7:0]      next_cfg,
  output logic [7:0]      cfg_q,
  output logic [XLEN-1:0] addr_q,
  output logic            cfg_taken,
  output logic            addr_taken
);

  logic cfg_ok;
  logic addr_ok;

  always_comb begin
    cfg_ok     = cfg_write_ok(ENHANCED, bypass, lockdown, cfg_q[BIT_LOCK], cfg_wdata);
    addr_ok    = addr_write_ok(cfg_q[BIT_LOCK], HAS_NEXT, next_cfg);
    cfg_taken  = cfg_we && cfg_ok;
    addr_taken = addr_we && addr_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_taken)  cfg_q  <= cfg_wdata;
      if (addr_taken) addr_q <= addr_wdata;
    end
  end

  // R6
  addr_self_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && cfg_q[BIT_LOCK]) |=> (addr_q == $past(addr_q)));

  // R7
  addr_succ_tor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && next_cfg[BIT_LOCK] && (next_cfg[4:3] == MODE_TOR) && HAS_NEXT)
      |=> (addr_q == $past(addr_q)));

  generate
    if (!ENHANCED) begin : g_base_chk
      // R3
      base_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[BIT_LOCK] |=> (cfg_q == $past(cfg_q)));
    end else begin : g_enh_chk
      // R4
      bypass_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && bypass) |=> (cfg_q == $past(cfg_wdata)));
    end
  endgenerate

endmodule

// File: rtl/prot_sec_reg.sv
module prot_sec_reg
  import prot_region_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wdata,
  input  logic       any_locked,
  output logic [2:0] sec_q
);

  logic [2:0] sec_d;

  always_comb sec_d = sec_next(sec_q, wdata, any_locked);

  always_ff @(posedge clk) begin
    if (!rst_n)  sec_q <= '0;
    else if (we) sec_q <= sec_d;
  end

  // R9
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[SEC_LOCKDOWN] |=> sec_q[SEC_LOCKDOWN]);

  // R9
  whitelist_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[SEC_WHITELIST] |=> sec_q[SEC_WHITELIST]);

  // R10
  bypass_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q[SEC_BYPASS] && any_locked) |=> !sec_q[SEC_BYPASS]);

endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux
  import prot_region_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 6
) (
  input  logic [1:0]                rd_kind,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic [8*N_ENTRIES-1:0]    cfg_flat,
  input  logic [XLEN*N_ENTRIES-1:0] addr_flat,
  input  logic [2:0]                sec_q,
  output logic [XLEN-1:0]           rd_data
);

  localparam int BYTES = XLEN / 8;

  always_comb begin
    rd_data = '0;
    case (rd_kind)
      KIND_CFG: begin
        for (int i = 0; i < BYTES; i++) begin
          if ((4 * int'(rd_idx) + i) < N_ENTRIES)
            rd_data[i*8 +: 8] = cfg_flat[(4 * int'(rd_idx) + i) * 8 +: 8];
        end
      end
      KIND_ADDR: begin
        if (int'(rd_idx) < N_ENTRIES)
          rd_data = addr_flat[int'(rd_idx) * XLEN +: XLEN];
      end
      KIND_SEC: rd_data = XLEN'(sec_q);
      default:  rd_data = '0;
    endcase
  end

endmodule

// File: rtl/prot_region_regs.sv
module prot_region_regs
  import prot_region_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int XLEN      = 32,
  parameter int IDX_W     = 6,
  parameter bit ENHANCED  = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [1:0]                wr_kind,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  input  logic [1:0]                rd_kind,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [XLEN-1:0]           rd_data,
  output logic [8*N_ENTRIES-1:0]    cfg_flat,
  output logic [XLEN*N_ENTRIES-1:0] addr_flat,
  output logic [2:0]                sec_state,
  output logic                      flush
);

  localparam int BYTES = XLEN / 8;

  logic [7:0]      cfg_arr    [N_ENTRIES];
  logic [XLEN-1:0] addr_arr   [N_ENTRIES];
  logic [7:0]      next_cfg_w [N_ENTRIES];
  logic [N_ENTRIES-1:0] lock_vec;
  logic [N_ENTRIES-1:0] cfg_taken_vec;
  logic [N_ENTRIES-1:0] addr_taken_vec;
  logic cfg_csr_wr;
  logic addr_csr_wr;
  logic sec_csr_wr;
  logic any_locked;

  always_comb begin
    cfg_csr_wr  = wr_en && (wr_kind == KIND_CFG);
    addr_csr_wr = wr_en && (wr_kind == KIND_ADDR);
    sec_csr_wr  = wr_en && (wr_kind == KIND_SEC);
    any_locked  = |lock_vec;
  end

  generate
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
      logic       cfg_hit;
      logic       addr_hit;
      logic [7:0] byte_w;
      int         lane;

      always_comb begin
        lane     = g - 4 * int'(wr_idx);
        cfg_hit  = cfg_csr_wr && (lane >= 0) && (lane < BYTES);
        addr_hit = addr_csr_wr && (int'(wr_idx) == g);
        byte_w   = cfg_hit ? 8'(wr_data >> (8 * lane)) : 8'h00;
      end

      if (g < N_ENTRIES - 1) begin : g_nx
        assign next_cfg_w[g] = cfg_arr[g+1];
      end else begin : g_last
        assign next_cfg_w[g] = 8'h00;
      end

      prot_entry #(
        .XLEN     (XLEN),
        .ENHANCED (ENHANCED),
        .HAS_NEXT (g < N_ENTRIES - 1)
      ) u_entry (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_hit),
        .cfg_wdata  (byte_w),
        .addr_we    (addr_hit),
        .addr_wdata (wr_data),
        .bypass     (sec_state[SEC_BYPASS]),
        .lockdown   (sec_state[SEC_LOCKDOWN]),
        .next_cfg   (next_cfg_w[g]),
        .cfg_q      (cfg_arr[g]),
        .addr_q     (addr_arr[g]),
        .cfg_taken  (cfg_taken_vec[g]),
        .addr_taken (addr_taken_vec[g])
      );

      assign lock_vec[g]              = cfg_arr[g][BIT_LOCK];
      assign cfg_flat[g*8 +: 8]       = cfg_arr[g];
      assign addr_flat[g*XLEN +: XLEN] = addr_arr[g];
    end
  endgenerate

  prot_sec_reg u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (sec_csr_wr),
    .wdata      (wr_data[2:0]),
    .any_locked (any_locked),
    .sec_q      (sec_state)
  );

  prot_read_mux #(
    .N_ENTRIES (N_ENTRIES),
    .XLEN      (XLEN),
    .IDX_W     (IDX_W)
  ) u_rd (
    .rd_kind   (rd_kind),
    .rd_idx    (rd_idx),
    .cfg_flat  (cfg_flat),
    .addr_flat (addr_flat),
    .sec_q     (sec_state),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flush <= 1'b0;
    else        flush <= cfg_csr_wr;
  end

  // R11
  flush_after_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_csr_wr |=> flush);

  // R11
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_csr_wr |=> !flush);

  // R8
  oob_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_csr_wr && (int'(wr_idx) >= N_ENTRIES)) |-> (addr_taken_vec == '0));

  // R2
  one_byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_csr_wr |-> (cfg_taken_vec == '0));

endmodule

// File: tb/prot_region_regs_tb.sv
module prot_region_regs_tb;

  localparam int N  = 16;
  localparam int XL = 32;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_kind = 2'd3;
  logic [IW-1:0] wr_idx = '0;
  logic [XL-1:0] wr_data = '0;
  logic [1:0]    rd_kind = 2'd3;
  logic [IW-1:0] rd_idx = '0;
  logic [XL-1:0] rd_data, rd_data_b;
  logic [8*N-1:0]  cfg_flat, cfg_flat_b;
  logic [XL*N-1:0] addr_flat, addr_flat_b;
  logic [2:0]    sec_state, sec_state_b;
  logic          flush, flush_b;

  int checks = 0;
  int errors = 0;
  int pending = 0;

  typedef struct {
    logic [1:0]    kind;
    int            idx;
    logic [XL-1:0] exp;
    bit            base;
    string         tag;
  } sb_item_t;

  sb_item_t sb_q[$];

  always #2 clk = ~clk;

  prot_region_regs #(.N_ENTRIES(N), .XLEN(XL), .IDX_W(IW), .ENHANCED(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data),
    .cfg_flat(cfg_flat), .addr_flat(addr_flat), .sec_state(sec_state), .flush(flush));

  prot_region_regs #(.N_ENTRIES(N), .XLEN(XL), .IDX_W(IW), .ENHANCED(1'b0)) u_dut_base (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_kind(rd_kind), .rd_idx(rd_idx), .rd_data(rd_data_b),
    .cfg_flat(cfg_flat_b), .addr_flat(addr_flat_b), .sec_state(sec_state_b), .flush(flush_b));

  task automatic compare(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads and compares half a cycle later
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      rd_kind = it.kind;
      rd_idx  = IW'(it.idx);
      #1;
      compare(it.tag, it.base ? rd_data_b : rd_data, it.exp);
      pending--;
    end
  end

  task automatic expect_rd(input logic [1:0] kind, input int idx, input logic [XL-1:0] exp,
                           input bit base, input string tag);
    sb_item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.base = base; it.tag = tag;
    pending++;
    sb_q.push_back(it);
    wait (pending == 0);
  endtask

  task automatic wr(input logic [1:0] kind, input int idx, input logic [XL-1:0] data);
    @(negedge clk);
    wr_kind = kind; wr_idx = IW'(idx); wr_data = data; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_kind = 2'd3;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    expect_rd(2'd0, 0, 32'h0, 0, "R1 cfg0");
    expect_rd(2'd1, 0, 32'h0, 0, "R1 addr0");
    expect_rd(2'd2, 0, 32'h0, 0, "R1 sec");
    compare("R1 flush", XL'(flush), 32'h0);

    // R11 timing and R2 byte split
    @(negedge clk);
    wr_kind = 2'd0; wr_idx = '0; wr_data = 32'h0B0A0903; wr_en = 1'b1;
    #1 compare("R11 before edge", cfg_flat[31:0], 32'h0);
    @(negedge clk);
    wr_en = 1'b0; wr_kind = 2'd3;
    compare("R11 after edge", cfg_flat[31:0], 32'h0B0A0903);
    compare("R11 flush high", XL'(flush), 32'h1);
    @(negedge clk);
    compare("R11 flush one cycle", XL'(flush), 32'h0);
    compare("R2 entry2 byte", XL'(cfg_flat[23:16]), 32'h0A);
    expect_rd(2'd0, 0, 32'h0B0A0903, 0, "R2 cfg0 readback");

    wr(2'd1, 5, 32'h1234);
    expect_rd(2'd1, 5, 32'h1234, 0, "R6 addr5 unlocked");

    // lock entry 4, then attempt rewrite
    wr(2'd0, 1, 32'h00000080);
    wr(2'd0, 1, 32'h00000001);
    expect_rd(2'd0, 1, 32'h00000080, 1, "R3 base locked drop");
    expect_rd(2'd0, 1, 32'h00000080, 0, "R4 enh locked drop");
    wr(2'd1, 4, 32'h55);
    expect_rd(2'd1, 4, 32'h0, 0, "R6 addr4 self locked");

    // R7 entry6 locked TOR protects addr5
    wr(2'd0, 1, 32'h00880080);
    expect_rd(2'd0, 1, 32'h00880080, 0, "R7 cfg1 set");
    wr(2'd1, 5, 32'h9999);
    expect_rd(2'd1, 5, 32'h1234, 0, "R7 addr5 tor blocked");
    wr(2'd1, 7, 32'h77);
    expect_rd(2'd1, 7, 32'h77, 0, "R7 addr7 free");
    wr(2'd0, 2, 32'h00900000);
    wr(2'd1, 9, 32'h42);
    expect_rd(2'd1, 9, 32'h42, 0, "R7 locked non-tor successor");

    // R8 out of range
    wr(2'd0, 4, 32'hFFFFFFFF);
    expect_rd(2'd0, 4, 32'h0, 0, "R8 cfg oob read");
    expect_rd(2'd0, 3, 32'h0, 0, "R8 cfg3 untouched");
    wr(2'd1, 16, 32'hABCD);
    expect_rd(2'd1, 16, 32'h0, 0, "R8 addr oob read");
    compare("R8 addr flat untouched", addr_flat[15*XL +: XL], 32'h0);
    expect_rd(2'd3, 0, 32'h0, 0, "R8 kind3 read");

    // R10 bypass blocked while locked
    wr(2'd2, 0, 32'h4);
    expect_rd(2'd2, 0, 32'h0, 0, "R10 bypass blocked");

    // R4 / R10 bypass path
    do_reset();
    wr(2'd2, 0, 32'h4);
    expect_rd(2'd2, 0, 32'h4, 0, "R10 bypass set unlocked");
    wr(2'd0, 0, 32'h00000080);
    wr(2'd0, 0, 32'h00000001);
    expect_rd(2'd0, 0, 32'h00000001, 0, "R4 bypass rewrite locked");
    expect_rd(2'd0, 0, 32'h00000080, 1, "R3 base ignores bypass");
    wr(2'd2, 0, 32'h0);
    wr(2'd0, 0, 32'h00000080);
    wr(2'd2, 0, 32'h4);
    expect_rd(2'd2, 0, 32'h0, 0, "R10 relock blocks bypass");

    // R5 lockdown policy, four cases in one CSR write
    do_reset();
    wr(2'd2, 0, 32'h1);
    expect_rd(2'd2, 0, 32'h1, 0, "R9 lockdown set");
    wr(2'd0, 0, 32'h07068184);
    expect_rd(2'd0, 0, 32'h07008100, 0, "R5 lockdown byte policy");
    expect_rd(2'd0, 0, 32'h07068184, 1, "R3 base unlocked accept");

    // R9 sticky
    wr(2'd2, 0, 32'h0);
    expect_rd(2'd2, 0, 32'h1, 0, "R9 lockdown sticky");
    wr(2'd2, 0, 32'h2);
    wr(2'd2, 0, 32'h0);
    expect_rd(2'd2, 0, 32'h3, 0, "R9 whitelist sticky");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule